// File: doc/BRIEF.md
# Dual-Window Bank-Switching Memory Mapper

This block lets an 8-bit CPU with a 16-bit address bus reach more physical memory than its 64 KB logical space can hold. The logical space is split into two 32 KB windows. The lower window (0x0000–0x7FFF) is served from read-only program chips. The upper window (0x8000–0xFFFF) is served from battery-backed data SRAMs. Each window has its own bank register, and the CPU loads it with a single-byte I/O output to that window's port. The CPU can read either register back through an I/O input on the same port.

The decode is purely combinational on the CPU strobes and the two registers. For every memory cycle it produces one chip select and a 17-bit address inside that chip. There are three 64 KB program chips. On the data side there are a 128 KB SRAM, an optional second 128 KB SRAM whose presence is given by a strap input, and a 32 KB SRAM. If the access names a bank that is not fitted, or writes to the read-only window, the block raises an error flag, drives no chip select, and returns 0xFF to the CPU.

Top module: `bank_mapper`

## Requirements
- R1: While reset is asserted, both bank registers clear to 0x00, so a read of logical 0x0000 selects program chip 0 at physical address 0, and I/O reads of both ports return 0x00.
- R2: An I/O write whose address low byte is 0x01 loads the program bank register, and one whose low byte is 0x02 loads the data bank register, at the next clock edge. An I/O read of either port returns that register's value. An I/O read of any other port returns 0xFF, and an I/O write to any other port leaves both registers unchanged. With the default parameters the upper address byte is ignored.
- R3: In a memory access to 0x0000–0x7FFF, the program register selects the chip: bits 7:1 are the block number b and bit 0 is the half h. For b in 0..2, prog_cs_o is one-hot at bit b and phys_addr_o = {1'b0, h, addr[14:0]}.
- R4: In a memory access to 0x8000–0xFFFF, the data register is split the same way. Blocks 0 and 1 select data_cs_o bit 0 (the first 128 KB SRAM) with phys_addr_o = {b[0], h, addr[14:0]}. Block 4 with h=0 selects data_cs_o bit 2 (the 32 KB SRAM) with phys_addr_o = {2'b00, addr[14:0]}. mem_we_o is high only for a memory write that has a data chip selected.
- R5: Blocks 2 and 3 select data_cs_o bit 1 (the second 128 KB SRAM) with phys_addr_o = {b[0], h, addr[14:0]}, but only while sram2_fitted_i is high. When it is low, these blocks are treated as not fitted.
- R6: A program block of 3 or more, a data block of 5 or more, data block 4 with h=1, or an unfitted block 2 or 3 asserts acc_err_o, drives all chip selects and mem_we_o low, and returns 0xFF on cpu_rdata_o for a read.
- R7: A memory write to 0x0000–0x7FFF asserts acc_err_o and drives no chip select and no write enable, whatever the program register holds.
- R8: With no memory strobe active, acc_err_o and all chip selects are low. At most one chip select is ever high.
- R9: A memory read with no error passes mem_rdata_i through to cpu_rdata_o. Memory accesses never change either bank register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | CPU address; the low byte is the port number during I/O cycles |
| cpu_wdata_i | input | 8 | CPU write data |
| mem_rd_i | input | 1 | Memory read strobe |
| mem_wr_i | input | 1 | Memory write strobe |
| io_rd_i | input | 1 | I/O read strobe |
| io_wr_i | input | 1 | I/O write strobe |
| sram2_fitted_i | input | 1 | Strap: second 128 KB data SRAM present |
| mem_rdata_i | input | 8 | Read data from the shared memory data bus |
| cpu_rdata_o | output | 8 | Read data to the CPU |
| prog_cs_o | output | 3 | One-hot program chip selects |
| data_cs_o | output | 3 | Data chip selects: bit 0 SRAM A, bit 1 SRAM B, bit 2 32 KB SRAM |
| phys_addr_o | output | 17 | Address within the selected chip |
| mem_we_o | output | 1 | Write enable to the selected data SRAM |
| acc_err_o | output | 1 | Access to an unfitted bank or write to program window |

## Verification
The hardest cases to reach are the ones where a register value that was legal becomes illegal only because of a second, unrelated input. Data block 2 or 3 depends on the strap, and data block 4 depends on the half bit. Both cases need an I/O write, a following memory cycle, and a strap change between accesses. The directed part loads each of these register values, then flips the strap and re-reads the same address. The random part draws register data from a small range around the legal block numbers and also toggles the strap, so that legal and illegal banks alternate often. A behavioural model predicts every output on every cycle.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned OFF_W     = 15;
  localparam int unsigned PHYS_W    = 17;
  localparam int unsigned NUM_WIN   = 2;
  localparam int unsigned DCS_W     = 3;
  localparam int unsigned BLK_W     = DATA_W - 1;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [BLK_W-1:0]  blk_t;
  typedef enum int unsigned {WIN_PROG = 0, WIN_DATA = 1} win_e;
endpackage

// File: rtl/bm_bank_reg.sv
module bm_bank_reg
  import bank_mapper_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ld_i,
  input  byte_t d_i,
  output byte_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/bm_prog_decode.sv
module bm_prog_decode
  import bank_mapper_pkg::*;
#(
  parameter int unsigned NUM_BLK = 3
) (
  input  logic               active_i,
  input  logic               wr_i,
  input  byte_t              bank_i,
  input  logic [OFF_W-1:0]   off_i,
  output logic [NUM_BLK-1:0] cs_o,
  output logic [PHYS_W-1:0]  addr_o,
  output logic               err_o
);
  blk_t blk;
  logic fitted;
  assign blk = bank_i[DATA_W-1:1];

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_cs
    assign cs_o[b] = active_i & ~wr_i & (blk == BLK_W'(b));
  end

  assign fitted = (32'(blk) < NUM_BLK);
  assign addr_o = {1'b0, bank_i[0], off_i};
  // read-only window: any write is an error
  assign err_o  = active_i & (wr_i | ~fitted);
endmodule

// File: rtl/bm_data_decode.sv
module bm_data_decode
  import bank_mapper_pkg::*;
#(
  parameter int unsigned BLK_PER_CHIP = 2,
  parameter int unsigned NUM_BIG      = 2
) (
  input  logic              active_i,
  input  logic              sram2_fitted_i,
  input  byte_t             bank_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [DCS_W-1:0]  cs_o,
  output logic [PHYS_W-1:0] addr_o,
  output logic              err_o
);
  localparam int unsigned SMALL_BLK = BLK_PER_CHIP * NUM_BIG;

  blk_t blk;
  logic half;
  logic [DCS_W-1:0] hit;
  assign blk  = bank_i[DATA_W-1:1];
  assign half = bank_i[0];

  always_comb begin
    hit    = '0;
    addr_o = {blk[0], half, off_i};
    if (32'(blk) < BLK_PER_CHIP) begin
      hit[0] = 1'b1;
    end else if (32'(blk) < SMALL_BLK) begin
      hit[1] = sram2_fitted_i;
    end else if (32'(blk) == SMALL_BLK) begin
      // small SRAM holds only one 32 KB half
      hit[2] = ~half;
      addr_o = {2'b00, off_i};
    end
  end

  assign cs_o  = active_i ? hit : '0;
  assign err_o = active_i & ~|hit;
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int unsigned NUM_PROG_BLK     = 3,
  parameter int unsigned PROG_PORT        = 1,
  parameter int unsigned DATA_PORT        = 2,
  parameter bit          FULL_PORT_DECODE = 1'b0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [15:0]             cpu_addr_i,
  input  logic [7:0]              cpu_wdata_i,
  input  logic                    mem_rd_i,
  input  logic                    mem_wr_i,
  input  logic                    io_rd_i,
  input  logic                    io_wr_i,
  input  logic                    sram2_fitted_i,
  input  logic [7:0]              mem_rdata_i,
  output logic [7:0]              cpu_rdata_o,
  output logic [NUM_PROG_BLK-1:0] prog_cs_o,
  output logic [2:0]              data_cs_o,
  output logic [16:0]             phys_addr_o,
  output logic                    mem_we_o,
  output logic                    acc_err_o
);
  byte_t bank_q [NUM_WIN];
  logic [NUM_WIN-1:0] port_hit;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int unsigned PORT = (w == WIN_PROG) ? PROG_PORT : DATA_PORT;
    if (FULL_PORT_DECODE) begin : g_full
      assign port_hit[w] = (cpu_addr_i == ADDR_W'(PORT));
    end else begin : g_low
      assign port_hit[w] = (cpu_addr_i[7:0] == 8'(PORT));
    end
    bm_bank_reg u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ld_i   (io_wr_i & port_hit[w]),
      .d_i    (cpu_wdata_i),
      .q_o    (bank_q[w])
    );
  end

  byte_t prog_bank, data_bank;
  assign prog_bank = bank_q[WIN_PROG];
  assign data_bank = bank_q[WIN_DATA];

  logic mem_acc, in_data;
  assign mem_acc = mem_rd_i | mem_wr_i;
  assign in_data = cpu_addr_i[ADDR_W-1];

  logic [PHYS_W-1:0] p_addr, d_addr;
  logic p_err, d_err;

  bm_prog_decode #(.NUM_BLK(NUM_PROG_BLK)) u_prog (
    .active_i (mem_acc & ~in_data),
    .wr_i     (mem_wr_i),
    .bank_i   (prog_bank),
    .off_i    (cpu_addr_i[OFF_W-1:0]),
    .cs_o     (prog_cs_o),
    .addr_o   (p_addr),
    .err_o    (p_err)
  );

  bm_data_decode u_data (
    .active_i       (mem_acc & in_data),
    .sram2_fitted_i (sram2_fitted_i),
    .bank_i         (data_bank),
    .off_i          (cpu_addr_i[OFF_W-1:0]),
    .cs_o           (data_cs_o),
    .addr_o         (d_addr),
    .err_o          (d_err)
  );

  assign phys_addr_o = in_data ? d_addr : p_addr;
  assign acc_err_o   = p_err | d_err;
  assign mem_we_o    = mem_wr_i & |data_cs_o;

  always_comb begin
    cpu_rdata_o = 8'hFF;
    if (mem_rd_i && !acc_err_o) begin
      cpu_rdata_o = mem_rdata_i;
    end else if (io_rd_i) begin
      for (int w = 0; w < NUM_WIN; w++)
        if (port_hit[w]) cpu_rdata_o = bank_q[w];
    end
  end
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
  parameter int unsigned NUM_PROG_BLK = 3,
  parameter int unsigned PROG_PORT    = 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [15:0]             cpu_addr_i,
  input logic                    mem_rd_i,
  input logic                    mem_wr_i,
  input logic                    io_rd_i,
  input logic                    io_wr_i,
  input logic                    sram2_fitted_i,
  input logic [7:0]              cpu_rdata_o,
  input logic [NUM_PROG_BLK-1:0] prog_cs_o,
  input logic [2:0]              data_cs_o,
  input logic                    mem_we_o,
  input logic                    acc_err_o,
  input logic [7:0]              prog_bank_i,
  input logic [7:0]              data_bank_i
);
  // R7
  prog_wr_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_i && !cpu_addr_i[15]) |-> (acc_err_o && prog_cs_o == '0 && !mem_we_o));

  // R6
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err_o |-> (prog_cs_o == '0 && data_cs_o == '0 && !mem_we_o));

  // R6
  err_read_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_err_o && mem_rd_i) |-> (cpu_rdata_o == 8'hFF));

  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_i || mem_wr_i) |-> (!acc_err_o && prog_cs_o == '0 && data_cs_o == '0));

  // R8
  single_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_cs_o, data_cs_o}));

  // R5
  no_sram2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram2_fitted_i |-> !data_cs_o[1]);

  // R9
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_wr_i |=> ($stable(prog_bank_i) && $stable(data_bank_i)));

  // R2
  prog_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && !mem_rd_i && cpu_addr_i[7:0] == 8'(PROG_PORT)) |-> (cpu_rdata_o == prog_bank_i));
endmodule

bind bank_mapper bank_mapper_chk #(.NUM_PROG_BLK(NUM_PROG_BLK), .PROG_PORT(PROG_PORT)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cpu_addr_i     (cpu_addr_i),
  .mem_rd_i       (mem_rd_i),
  .mem_wr_i       (mem_wr_i),
  .io_rd_i        (io_rd_i),
  .io_wr_i        (io_wr_i),
  .sram2_fitted_i (sram2_fitted_i),
  .cpu_rdata_o    (cpu_rdata_o),
  .prog_cs_o      (prog_cs_o),
  .data_cs_o      (data_cs_o),
  .mem_we_o       (mem_we_o),
  .acc_err_o      (acc_err_o),
  .prog_bank_i    (prog_bank),
  .data_bank_i    (data_bank)
);

// File: tb/bank_mapper_tb.sv
module bank_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, mrdata = '0;
  logic        mem_rd = 0, mem_wr = 0, io_rd = 0, io_wr = 0;
  logic        strap = 1'b0;
  logic [7:0]  rdata;
  logic [2:0]  pcs, dcs;
  logic [16:0] paddr;
  logic        we, err;

  int checks = 0, errors = 0;
  int pb = 0, db = 0;

  always #10 clk = ~clk;

  bank_mapper u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr), .cpu_wdata_i(wdata),
    .mem_rd_i(mem_rd), .mem_wr_i(mem_wr), .io_rd_i(io_rd), .io_wr_i(io_wr),
    .sram2_fitted_i(strap), .mem_rdata_i(mrdata), .cpu_rdata_o(rdata),
    .prog_cs_o(pcs), .data_cs_o(dcs), .phys_addr_o(paddr),
    .mem_we_o(we), .acc_err_o(err)
  );

  task automatic compare(input string tag);
    int blk, half, eaddr;
    logic [2:0] epcs, edcs;
    logic [7:0] erd;
    bit eerr, ewe;
    epcs = '0; edcs = '0; eerr = 0; eaddr = 0;
    if (mem_rd || mem_wr) begin
      if (addr < 16'h8000) begin
        blk = pb >> 1; half = pb & 1;
        if (mem_wr || blk >= 3) eerr = 1;
        else begin epcs[blk] = 1'b1; eaddr = half * 32768 + (addr & 16'h7FFF); end
      end else begin
        blk = db >> 1; half = db & 1;
        if (blk <= 1) begin edcs = 3'b001; eaddr = blk * 65536 + half * 32768 + (addr & 16'h7FFF); end
        else if (blk <= 3 && strap) begin edcs = 3'b010; eaddr = (blk - 2) * 65536 + half * 32768 + (addr & 16'h7FFF); end
        else if (blk == 4 && half == 0) begin edcs = 3'b100; eaddr = addr & 16'h7FFF; end
        else eerr = 1;
      end
    end
    ewe = mem_wr && (edcs != 0);
    erd = 8'hFF;
    if (mem_rd && !eerr) erd = mrdata;
    else if (io_rd && addr[7:0] == 8'h01) erd = 8'(pb);
    else if (io_rd && addr[7:0] == 8'h02) erd = 8'(db);
    checks++;
    if (pcs !== epcs || dcs !== edcs || err !== eerr || we !== ewe || rdata !== erd ||
        ((epcs != 0 || edcs != 0) && paddr !== 17'(eaddr))) begin
      errors++;
      $display("FAIL %s: pcs=%b dcs=%b err=%b we=%b rd=%h pa=%h exp pcs=%b dcs=%b err=%b we=%b rd=%h pa=%h",
               tag, pcs, dcs, err, we, rdata, paddr, epcs, edcs, eerr, ewe, erd, 17'(eaddr));
    end
  endtask

  task automatic op(input string tag, input bit mr, mw, ir, iw,
                    input logic [15:0] a, input logic [7:0] wd);
    @(negedge clk);
    mem_rd = mr; mem_wr = mw; io_rd = ir; io_wr = iw;
    addr = a; wdata = wd; mrdata = 8'($urandom);
    #5;
    compare(tag);
    @(posedge clk);
    if (iw && rst_n) begin
      if (a[7:0] == 8'h01) pb = wd;
      else if (a[7:0] == 8'h02) db = wd;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    op("R1 prog port after reset", 0, 0, 1, 0, 16'h0001, 0);
    op("R1 data port after reset", 0, 0, 1, 0, 16'h0002, 0);
    op("R1 boot fetch", 1, 0, 0, 0, 16'h0000, 0);
    // R8 idle
    op("R8 idle", 0, 0, 0, 0, 16'h9000, 0);
    // R3 program banking
    op("R2 load prog", 0, 0, 0, 1, 16'h0001, 8'h05);
    op("R2 readback prog", 0, 0, 1, 0, 16'h0001, 0);
    op("R3 blk2 upper half", 1, 0, 0, 0, 16'h1234, 0);
    op("R2 load prog", 0, 0, 0, 1, 16'h0001, 8'h02);
    op("R3 blk1 lower half", 1, 0, 0, 0, 16'h7FFF, 0);
    op("R7 prog write", 0, 1, 0, 0, 16'h0100, 8'h55);
    op("R2 load prog", 0, 0, 0, 1, 16'h0001, 8'h06);
    op("R6 prog blk3 missing", 1, 0, 0, 0, 16'h0040, 0);
    // R2 other ports ignored, high byte ignored
    op("R2 foreign port", 0, 0, 0, 1, 16'h0003, 8'h7E);
    op("R2 foreign port read", 0, 0, 1, 0, 16'h0003, 0);
    op("R2 prog unchanged", 0, 0, 1, 0, 16'h0001, 0);
    op("R2 high byte ignored", 0, 0, 0, 1, 16'h0101, 8'h00);
    op("R2 readback after high byte", 0, 0, 1, 0, 16'h0001, 0);
    // R4 data banking
    op("R2 load data", 0, 0, 0, 1, 16'h0002, 8'h03);
    op("R4 sram1 blk1 upper", 1, 0, 0, 0, 16'h8010, 0);
    op("R4 sram1 write", 0, 1, 0, 0, 16'hFFFE, 8'hA5);
    op("R9 data unchanged", 0, 0, 1, 0, 16'h0002, 0);
    // R5 strap
    strap = 1'b0;
    op("R2 load data", 0, 0, 0, 1, 16'h0002, 8'h04);
    op("R5 sram2 absent", 1, 0, 0, 0, 16'h8200, 0);
    op("R5 sram2 absent write", 0, 1, 0, 0, 16'h8200, 8'h11);
    strap = 1'b1;
    op("R5 sram2 fitted", 1, 0, 0, 0, 16'h8200, 0);
    op("R2 load data", 0, 0, 0, 1, 16'h0002, 8'h07);
    op("R5 sram2 blk3 write", 0, 1, 0, 0, 16'hC001, 8'h22);
    // R4/R6 small SRAM
    op("R2 load data", 0, 0, 0, 1, 16'h0002, 8'h08);
    op("R4 small sram", 1, 0, 0, 0, 16'hABCD, 0);
    op("R2 load data", 0, 0, 0, 1, 16'h0002, 8'h09);
    op("R6 small sram upper half", 1, 0, 0, 0, 16'hABCD, 0);
    op("R2 load data", 0, 0, 0, 1, 16'h0002, 8'h0A);
    op("R6 data blk5 missing", 0, 1, 0, 0, 16'h8000, 8'h33);
    op("R9 data unchanged", 0, 0, 1, 0, 16'h0002, 0);

    // R3/R4 random mix
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [15:0] a;
      k = $urandom_range(0, 6);
      if ($urandom_range(0, 15) == 0) strap = ~strap;
      case (k)
        0: begin
          case ($urandom_range(0, 4))
            0: a = 16'h0001; 1: a = 16'h0002; 2: a = 16'h0003;
            3: a = 16'h0201; default: a = 16'h0102;
          endcase
          op("R2 random io write", 0, 0, 0, 1, a, 8'($urandom_range(0, 11)));
        end
        1: op("R2 random io read", 0, 0, 1, 0, 16'($urandom_range(0, 3)), 0);
        2, 3: op("R3/R4 random read", 1, 0, 0, 0, 16'($urandom), 0);
        4, 5: op("R4/R7 random write", 0, 1, 0, 0, 16'($urandom), 8'($urandom));
        default: op("R8 random idle", 0, 0, 0, 0, 16'($urandom), 0);
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule